// File: doc/BRIEF.md
# Guest Exit Intercept Decoder

This block decides whether an event raised by a guest must hand control back to the hypervisor. The host loads six intercept bitmaps through a write port:

- control-register read and write masks, 16 bits each;
- debug-register read and write masks, 16 bits each;
- a 32-bit exception mask;
- a 64-bit general mask.

The host also raises a guest-mode flag when it enters the guest.

Each request carries a 12-bit exit code. The code space is cut into windows. Each window tests the bit of its own mask that is selected by the code's distance from the window base. Every code outside those windows tests the general mask, indexed from the interrupt code. A verdict comes back one clock after the request, together with a valid strobe.

When the host resumes, it pulses a return input. This drops guest mode and clears the general and exception masks. The control-register and debug-register masks are kept.

Top module: `gx_intercept`

## Requirements
- R1: Codes 0x000..0x008 hit when bit (code − 0x000) of the control-register read mask is set. Codes 0x009..0x00F never hit, whatever bits 9..15 of that mask hold.
- R2: Codes 0x010..0x018 hit when bit (code − 0x010) of the control-register write mask is set.
- R3: Codes 0x020..0x027 test bit (code − 0x020) of the debug-register read mask. Codes 0x030..0x037 test bit (code − 0x030) of the debug-register write mask. Codes 0x028..0x02F never hit.
- R4: Codes 0x040..0x05F hit when bit (code − 0x040) of the exception mask is set.
- R5: Any other code hits when bit (code − 0x060) of the general mask is set and that index lies in 0..63. A negative index or an index of 64 or more never hits.
- R6: While guest mode is clear, the verdict is never a hit.
- R7: A return pulse clears guest mode, the general mask and the exception mask, and keeps the other four masks. A return pulse overrides an enter pulse in the same cycle.
- R8: A write with cfg_we_i loads cfg_data_i into the mask chosen by cfg_sel_i, taking the low bits for narrow masks. The cfg_sel_i encoding is 0 control read, 1 control write, 2 debug read, 3 debug write, 4 exception, 5 general. Selector values 6 and 7 change nothing.
- R9: resp_valid_o is high exactly one cycle after req_valid_i, and resp_hit_o is low whenever resp_valid_o is low. The verdict uses the state from before the request's clock edge, so a write or return in the same cycle does not affect it.
- R10: After reset, guest mode is clear, all masks are zero and resp_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Mask write strobe |
| cfg_sel_i | input | 3 | Mask selector |
| cfg_data_i | input | 64 | Mask write data |
| guest_enter_i | input | 1 | Set guest mode |
| host_return_i | input | 1 | Return to host: clear guest mode and the general and exception masks |
| req_valid_i | input | 1 | Exit-code request strobe |
| req_code_i | input | 12 | Exit code |
| resp_valid_o | output | 1 | Verdict valid, one cycle after the request |
| resp_hit_o | output | 1 | Intercept verdict |

## Verification
A lookup can land in the same cycle as a state change: a return pulse, or a write to the mask that the lookup reads. The bench provokes both. It drives a request for a general-mask code in the same cycle as a return pulse and expects the old hit. It drives a request for an unset general bit together with a write that sets that bit and expects no hit. A repeat request one cycle later must then show the new state, which separates a verdict taken before the edge from one taken after it.

// File: rtl/gx_pkg.sv
package gx_pkg;
  localparam int unsigned GX_CODE_W     = 12;
  localparam int unsigned GX_CR_RD_BASE = 'h000;
  localparam int unsigned GX_CR_WR_BASE = 'h010;
  localparam int unsigned GX_DR_RD_BASE = 'h020;
  localparam int unsigned GX_DR_WR_BASE = 'h030;
  localparam int unsigned GX_EXC_BASE   = 'h040;
  localparam int unsigned GX_INTR_BASE  = 'h060;
  localparam int unsigned GX_CR_SPAN    = 9;
  localparam int unsigned GX_DR_SPAN    = 8;
  localparam int unsigned GX_REG_W      = 16;
  localparam int unsigned GX_EXC_W      = 32;
  localparam int unsigned GX_GEN_W      = 64;
  localparam int unsigned GX_NUM_WIN    = 5;

  typedef enum logic [2:0] {
    SEL_CR_RD = 3'd0,
    SEL_CR_WR = 3'd1,
    SEL_DR_RD = 3'd2,
    SEL_DR_WR = 3'd3,
    SEL_EXC   = 3'd4,
    SEL_GEN   = 3'd5
  } gx_sel_e;
endpackage

// File: rtl/gx_mask_bank.sv
module gx_mask_bank #(
  parameter int unsigned REG_W = 16,
  parameter int unsigned EXC_W = 32,
  parameter int unsigned GEN_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       sel_i,
  input  logic [GEN_W-1:0] data_i,
  input  logic             enter_i,
  input  logic             leave_i,
  output logic [REG_W-1:0] cr_rd_o,
  output logic [REG_W-1:0] cr_wr_o,
  output logic [REG_W-1:0] dr_rd_o,
  output logic [REG_W-1:0] dr_wr_o,
  output logic [EXC_W-1:0] exc_o,
  output logic [GEN_W-1:0] gen_o,
  output logic             guest_o
);
  import gx_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr_rd_o <= '0;
      cr_wr_o <= '0;
      dr_rd_o <= '0;
      dr_wr_o <= '0;
      exc_o   <= '0;
      gen_o   <= '0;
      guest_o <= 1'b0;
    end else begin
      if (we_i) begin
        case (gx_sel_e'(sel_i))
          SEL_CR_RD: cr_rd_o <= data_i[REG_W-1:0];
          SEL_CR_WR: cr_wr_o <= data_i[REG_W-1:0];
          SEL_DR_RD: dr_rd_o <= data_i[REG_W-1:0];
          SEL_DR_WR: dr_wr_o <= data_i[REG_W-1:0];
          SEL_EXC:   exc_o   <= data_i[EXC_W-1:0];
          SEL_GEN:   gen_o   <= data_i;
          default:   ;
        endcase
      end
      // return to host overrides both a same-cycle write and enter
      if (leave_i) begin
        exc_o   <= '0;
        gen_o   <= '0;
        guest_o <= 1'b0;
      end else if (enter_i) begin
        guest_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/gx_window.sv
module gx_window #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned BASE   = 0,
  parameter int unsigned SPAN   = 9,
  parameter int unsigned MASK_W = 32,
  localparam int unsigned IDX_W = $clog2(MASK_W)
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              in_o,
  output logic              hit_o
);
  localparam logic [CODE_W:0] LO = (CODE_W+1)'(BASE);
  localparam logic [CODE_W:0] HI = (CODE_W+1)'(BASE + SPAN);

  logic [IDX_W-1:0] idx;

  always_comb begin
    in_o  = ({1'b0, code_i} >= LO) && ({1'b0, code_i} < HI);
    idx   = IDX_W'(code_i - CODE_W'(BASE));
    hit_o = in_o && mask_i[idx];
  end
endmodule

// File: rtl/gx_verdict.sv
module gx_verdict (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic guest_i,
  input  logic hit_i,
  output logic resp_valid_o,
  output logic resp_hit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
    end else begin
      resp_valid_o <= req_valid_i;
      resp_hit_o   <= req_valid_i && guest_i && hit_i;
    end
  end
endmodule

// File: rtl/gx_intercept.sv
module gx_intercept #(
  parameter int unsigned CODE_W     = gx_pkg::GX_CODE_W,
  parameter int unsigned CR_RD_BASE = gx_pkg::GX_CR_RD_BASE,
  parameter int unsigned CR_WR_BASE = gx_pkg::GX_CR_WR_BASE,
  parameter int unsigned DR_RD_BASE = gx_pkg::GX_DR_RD_BASE,
  parameter int unsigned DR_WR_BASE = gx_pkg::GX_DR_WR_BASE,
  parameter int unsigned EXC_BASE   = gx_pkg::GX_EXC_BASE,
  parameter int unsigned INTR_BASE  = gx_pkg::GX_INTR_BASE,
  parameter int unsigned CR_SPAN    = gx_pkg::GX_CR_SPAN,
  parameter int unsigned DR_SPAN    = gx_pkg::GX_DR_SPAN,
  parameter int unsigned REG_W      = gx_pkg::GX_REG_W,
  parameter int unsigned EXC_W      = gx_pkg::GX_EXC_W,
  parameter int unsigned GEN_W      = gx_pkg::GX_GEN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_sel_i,
  input  logic [GEN_W-1:0]  cfg_data_i,
  input  logic              guest_enter_i,
  input  logic              host_return_i,
  input  logic              req_valid_i,
  input  logic [CODE_W-1:0] req_code_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o
);
  localparam int unsigned NW = gx_pkg::GX_NUM_WIN;
  localparam int unsigned WIN_BASE [NW] = '{CR_RD_BASE, CR_WR_BASE, DR_RD_BASE, DR_WR_BASE, EXC_BASE};
  localparam int unsigned WIN_SPAN [NW] = '{CR_SPAN, CR_SPAN, DR_SPAN, DR_SPAN, EXC_W};

  logic [REG_W-1:0] cr_rd, cr_wr, dr_rd, dr_wr;
  logic [EXC_W-1:0] exc;
  logic [GEN_W-1:0] gen;
  logic             guest;
  logic [EXC_W-1:0] win_mask [NW];
  logic [NW-1:0]    win_in, win_hit;
  logic             gen_in, gen_hit, hit;

  gx_mask_bank #(.REG_W(REG_W), .EXC_W(EXC_W), .GEN_W(GEN_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .data_i  (cfg_data_i),
    .enter_i (guest_enter_i),
    .leave_i (host_return_i),
    .cr_rd_o (cr_rd),
    .cr_wr_o (cr_wr),
    .dr_rd_o (dr_rd),
    .dr_wr_o (dr_wr),
    .exc_o   (exc),
    .gen_o   (gen),
    .guest_o (guest)
  );

  always_comb begin
    win_mask[0] = EXC_W'(cr_rd);
    win_mask[1] = EXC_W'(cr_wr);
    win_mask[2] = EXC_W'(dr_rd);
    win_mask[3] = EXC_W'(dr_wr);
    win_mask[4] = exc;
  end

  for (genvar w = 0; w < NW; w++) begin : g_win
    gx_window #(
      .CODE_W (CODE_W),
      .BASE   (WIN_BASE[w]),
      .SPAN   (WIN_SPAN[w]),
      .MASK_W (EXC_W)
    ) u_win (
      .code_i (req_code_i),
      .mask_i (win_mask[w]),
      .in_o   (win_in[w]),
      .hit_o  (win_hit[w])
    );
  end

  gx_window #(
    .CODE_W (CODE_W),
    .BASE   (INTR_BASE),
    .SPAN   (GEN_W),
    .MASK_W (GEN_W)
  ) u_gen (
    .code_i (req_code_i),
    .mask_i (gen),
    .in_o   (gen_in),
    .hit_o  (gen_hit)
  );

  // general mask only answers codes that no dedicated window claims
  assign hit = (|win_in) ? (|win_hit) : (gen_in && gen_hit);

  gx_verdict u_verdict (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .guest_i      (guest),
    .hit_i        (hit),
    .resp_valid_o (resp_valid_o),
    .resp_hit_o   (resp_hit_o)
  );
endmodule

// File: rtl/gx_intercept_chk.sv
module gx_intercept_chk #(
  parameter int unsigned CODE_W = gx_pkg::GX_CODE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [CODE_W-1:0] req_code_i,
  input logic              host_return_i,
  input logic              resp_valid_o,
  input logic              resp_hit_o
);
  import gx_pkg::*;
  localparam logic [CODE_W:0] GEN_END = (CODE_W+1)'(GX_INTR_BASE + GX_GEN_W);
  localparam logic [CODE_W:0] CR_GAP  = (CODE_W+1)'(GX_CR_RD_BASE + GX_CR_SPAN);
  localparam logic [CODE_W:0] CR_NEXT = (CODE_W+1)'(GX_CR_WR_BASE);

  assert_valid_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);

  assert_valid_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !resp_valid_o);

  assert_hit_qualified_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_hit_o |-> resp_valid_o);

  assert_return_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_return_i ##1 req_valid_i |=> !resp_hit_o);

  assert_gen_limit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ({1'b0, req_code_i} >= GEN_END)) |=> !resp_hit_o);

  assert_cr_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ({1'b0, req_code_i} >= CR_GAP) && ({1'b0, req_code_i} < CR_NEXT))
      |=> !resp_hit_o);
endmodule

bind gx_intercept gx_intercept_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_code_i    (req_code_i),
  .host_return_i (host_return_i),
  .resp_valid_o  (resp_valid_o),
  .resp_hit_o    (resp_hit_o)
);

// File: tb/sim_gx_intercept.sv
module sim_gx_intercept;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_sel_i = '0;
  logic [63:0] cfg_data_i = '0;
  logic        guest_enter_i = 1'b0;
  logic        host_return_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [11:0] req_code_i = '0;
  logic        resp_valid_o, resp_hit_o;
  int          checks = 0;
  int          errors = 0;

  always #10 clk_i = ~clk_i;

  gx_intercept u0 (.*);

  // {code, expected hit}, walked while in guest mode with the masks of load_masks
  localparam int NV = 19;
  localparam logic [12:0] VEC [NV] = '{
    {12'h000, 1'b1}, {12'h001, 1'b0}, {12'h008, 1'b1}, {12'h009, 1'b0},
    {12'h010, 1'b0}, {12'h011, 1'b1}, {12'h027, 1'b1}, {12'h028, 1'b0},
    {12'h030, 1'b1}, {12'h040, 1'b1}, {12'h04E, 1'b1}, {12'h05F, 1'b1},
    {12'h041, 1'b0}, {12'h060, 1'b1}, {12'h064, 1'b1}, {12'h09F, 1'b1},
    {12'h061, 1'b0}, {12'h0A0, 1'b0}, {12'h3FF, 1'b0}
  };

  function automatic string tag_of(input logic [11:0] c);
    if (c < 12'h010) return "R1";
    if (c < 12'h020) return "R2";
    if (c < 12'h040) return "R3";
    if (c < 12'h060) return "R4";
    return "R5";
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; pulses last one cycle
  task automatic wr(input logic [2:0] sel, input logic [63:0] d);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_data_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic pulse(input bit enter, input bit ret);
    guest_enter_i = enter; host_return_i = ret;
    @(negedge clk_i);
    guest_enter_i = 1'b0; host_return_i = 1'b0;
  endtask

  // same-cycle strobes may be set by the caller just before
  task automatic do_req(input logic [11:0] code, input bit exp, input string tag);
    req_valid_i = 1'b1; req_code_i = code;
    @(negedge clk_i);
    req_valid_i = 1'b0; cfg_we_i = 1'b0;
    host_return_i = 1'b0; guest_enter_i = 1'b0;
    check(resp_valid_o == 1'b1, tag, resp_valid_o, 1);
    check(resp_hit_o == exp, tag, resp_hit_o, exp);
  endtask

  task automatic load_masks();
    wr(3'd0, 64'h0305);                 // bits 0,2,8,9
    wr(3'd1, 64'h0002);                 // bit 1
    wr(3'd2, 64'h0180);                 // bits 7,8
    wr(3'd3, 64'h0001);                 // bit 0
    wr(3'd4, 64'h8000_4001);            // bits 0,14,31
    wr(3'd5, 64'h8000_0000_0000_0011);  // bits 0,4,63
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    check(resp_valid_o == 1'b0, "R10", resp_valid_o, 0);
    check(resp_hit_o == 1'b0, "R10", resp_hit_o, 0);
    pulse(1'b1, 1'b0);
    do_req(12'h000, 1'b0, "R10");
    pulse(1'b0, 1'b1);

    // R6: masks loaded, guest clear
    load_masks();
    do_req(12'h000, 1'b0, "R6");
    do_req(12'h060, 1'b0, "R6");

    pulse(1'b1, 1'b0);
    for (int i = 0; i < NV; i++)
      do_req(VEC[i][12:1], VEC[i][0], tag_of(VEC[i][12:1]));

    // R9: no request -> no valid
    @(negedge clk_i);
    check(resp_valid_o == 1'b0, "R9", resp_valid_o, 0);

    // R8: selectors 6 and 7 ignored
    wr(3'd6, '1);
    wr(3'd7, '1);
    do_req(12'h061, 1'b0, "R8");
    do_req(12'h002, 1'b1, "R8");
    do_req(12'h001, 1'b0, "R8");

    // R9: return in the same cycle as a request sees old state
    host_return_i = 1'b1;
    do_req(12'h060, 1'b1, "R9");
    do_req(12'h060, 1'b0, "R7");
    pulse(1'b1, 1'b0);
    do_req(12'h060, 1'b0, "R7");
    do_req(12'h040, 1'b0, "R7");
    do_req(12'h000, 1'b1, "R7");
    do_req(12'h030, 1'b1, "R7");

    // R8/R9: write of the probed mask in the same cycle
    cfg_we_i = 1'b1; cfg_sel_i = 3'd5; cfg_data_i = 64'h2;
    do_req(12'h061, 1'b0, "R9");
    do_req(12'h061, 1'b1, "R8");
    cfg_we_i = 1'b1; cfg_sel_i = 3'd4; cfg_data_i = 64'h4;
    do_req(12'h042, 1'b0, "R9");
    do_req(12'h042, 1'b1, "R4");

    // R7: return wins over a same-cycle enter
    pulse(1'b1, 1'b1);
    do_req(12'h000, 1'b0, "R7");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule